// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable combinational logic array. Sixteen data inputs feed a plane of 48 product terms. Each term ANDs any chosen subset of the inputs, taking each input either true or inverted. A second plane ORs any set of those terms into each of 8 outputs. A single term may feed several outputs at once. Each OR result then passes through an XOR with a per-output polarity bit.

The configuration is loaded word by word through a synchronous write port into a staging copy. A commit strobe moves the staged copy into the live configuration that drives evaluation. The path from the data inputs to the outputs holds no register.

The outputs leave the block as a data vector plus an enable vector. This lets a surrounding pad ring build either three-state drivers or open-collector drivers. A chip-enable input inhibits every output. When inhibited, the outputs float in three-state mode and are released to the pull-up level in open-collector mode.

Top module: `sop_array`

## Requirements
- R1: Term t is configured by the word at address t (0..47). Bit 2i is the true-enable and bit 2i+1 is the complement-enable for input i. A term is 1 unless some enabled literal is 0. An input with both bits clear is don't-care, so a term whose word is all zero is always 1.
- R2: If both enable bits of any input are set in a term's word, that term is 0 for every input vector.
- R3: The OR map of output o lives at two addresses. Address 48+2o bit b connects term b (0..31). Address 49+2o bit b connects term 32+b (b = 0..15). The OR result is 1 when any connected term is 1 and 0 when no connected term is 1. One term may drive several outputs.
- R4: Bits 7:0 of the word at address 64 are the polarity bits. Each output function equals its OR result XOR its polarity bit.
- R5: Writes (cfg_wr high at a rising edge) change only the staging copy. A cfg_commit high at a rising edge copies the staging copy, as it stood before that edge, into the live configuration. A write in the commit cycle therefore waits for the next commit. Without a commit, the outputs do not change.
- R6: A synchronous reset leaves all AND and OR connections intact, all polarity bits 0 and three-state mode selected, in both the staging and live copies. With chip_en high, dout is 0 and doe is all ones.
- R7: In three-state mode (bit 8 of address 64 is 0), chip_en high gives doe all ones and dout equal to the output functions. chip_en low gives doe 0 and dout 0.
- R8: In open-collector mode (bit 8 of address 64 is 1), dout is always 0. doe[o] is high only when chip_en is high and output function o is 0.
- R9: Evaluation is combinational: a change on din or chip_en reaches dout and doe without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration port |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe into the staging copy |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word |
| cfg_commit | input | 1 | Copy staging into the live configuration |
| chip_en | input | 1 | Active-high chip enable; low inhibits all outputs |
| din | input | 16 | Data inputs |
| dout | output | 8 | Driven output level |
| doe | output | 8 | Per-output drive enable |

## Verification
Single-literal terms on chosen inputs walk through all four values of an input pair. This separates the true literal, the complement literal and don't-care, and a doubled literal shows up as a term that never fires. A term placed in the upper OR word proves that the second half of each OR map is decoded. Polarity patterns and a mode switch under chip-enable toggling show whether the XOR, the inhibit and the open-collector drive each act on their own. Several random configurations with random input vectors are compared against a behavioural model kept in the bench. Writes issued without a commit, and a write issued together with a commit, confirm that nothing reaches the outputs early.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int DEF_N_IN   = 16;
    localparam int DEF_N_TERM = 48;
    localparam int DEF_N_OUT  = 8;
    localparam int DEF_WORD_W = 32;

    typedef enum logic {
        MODE_TRI = 1'b0,
        MODE_OC  = 1'b1
    } out_mode_e;

    function automatic int words_for(input int bits, input int word_w);
        return (bits + word_w - 1) / word_w;
    endfunction

    function automatic int ctrl_addr(input int n_term, input int n_out, input int word_w);
        return n_term + n_out * words_for(n_term, word_w);
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
    import sop_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_OUT  = DEF_N_OUT,
    parameter int WORD_W = DEF_WORD_W,
    parameter int ADDR_W = 7
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_wr,
    input  logic [ADDR_W-1:0]                   cfg_addr,
    input  logic [WORD_W-1:0]                   cfg_wdata,
    input  logic                                cfg_commit,
    output logic [N_TERM-1:0][2*N_IN-1:0]       live_and,
    output logic [N_OUT-1:0][N_TERM-1:0]        live_or,
    output logic [N_OUT-1:0]                    live_pol,
    output out_mode_e                           live_mode
);
    localparam int OR_WORDS = words_for(N_TERM, WORD_W);
    localparam int CTRL_A   = ctrl_addr(N_TERM, N_OUT, WORD_W);

    logic [N_TERM-1:0][2*N_IN-1:0] stage_and;
    logic [N_OUT-1:0][N_TERM-1:0]  stage_or;
    logic [N_OUT-1:0]              stage_pol;
    out_mode_e                     stage_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_and  <= '1;
            stage_or   <= '1;
            stage_pol  <= '0;
            stage_mode <= MODE_TRI;
        end else if (cfg_wr) begin
            for (int t = 0; t < N_TERM; t++) begin
                if (cfg_addr == ADDR_W'(t))
                    stage_and[t] <= cfg_wdata[2*N_IN-1:0];
            end
            for (int o = 0; o < N_OUT; o++) begin
                for (int t = 0; t < N_TERM; t++) begin
                    if (cfg_addr == ADDR_W'(N_TERM + o*OR_WORDS + t/WORD_W))
                        stage_or[o][t] <= cfg_wdata[t % WORD_W];
                end
            end
            if (cfg_addr == ADDR_W'(CTRL_A)) begin
                stage_pol  <= cfg_wdata[N_OUT-1:0];
                stage_mode <= out_mode_e'(cfg_wdata[N_OUT]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_and  <= '1;
            live_or   <= '1;
            live_pol  <= '0;
            live_mode <= MODE_TRI;
        end else if (cfg_commit) begin
            live_and  <= stage_and;
            live_or   <= stage_or;
            live_pol  <= stage_pol;
            live_mode <= stage_mode;
        end
    end

    // R5: live copy holds between commits
    assert_live_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_commit |=> ($stable(live_and) && $stable(live_or) &&
                         $stable(live_pol) && $stable(live_mode)));

    // R5: commit takes the staging copy as it was before the edge
    assert_commit_copy_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_commit |=> (live_and == $past(stage_and) && live_or == $past(stage_or) &&
                        live_pol == $past(stage_pol)));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48
) (
    input  logic [N_IN-1:0]                din,
    input  logic [N_TERM-1:0][2*N_IN-1:0]  and_map,
    output logic [N_TERM-1:0]              terms
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic hit;
        always_comb begin
            hit = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (and_map[t][2*i]   && !din[i]) hit = 1'b0;
                if (and_map[t][2*i+1] &&  din[i]) hit = 1'b0;
            end
        end
        assign terms[t] = hit;
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8
) (
    input  logic [N_TERM-1:0]             terms,
    input  logic [N_OUT-1:0][N_TERM-1:0]  or_map,
    input  logic [N_OUT-1:0]              pol,
    output logic [N_OUT-1:0]              func
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign func[o] = pol[o] ^ (|(or_map[o] & terms));
    end
endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage
    import sop_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic [N_OUT-1:0] func,
    input  logic             chip_en,
    input  out_mode_e        mode,
    output logic [N_OUT-1:0] dout,
    output logic [N_OUT-1:0] doe
);
    always_comb begin
        if (mode == MODE_OC) begin
            dout = '0;
            doe  = chip_en ? ~func : '0;
        end else begin
            dout = chip_en ? func : '0;
            doe  = {N_OUT{chip_en}};
        end
    end
endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_TERM = DEF_N_TERM,
    parameter int N_OUT  = DEF_N_OUT,
    parameter int WORD_W = DEF_WORD_W,
    parameter int ADDR_W = $clog2(ctrl_addr(N_TERM, N_OUT, WORD_W) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_commit,
    input  logic              chip_en,
    input  logic [N_IN-1:0]   din,
    output logic [N_OUT-1:0]  dout,
    output logic [N_OUT-1:0]  doe
);
    logic [N_TERM-1:0][2*N_IN-1:0] and_map;
    logic [N_OUT-1:0][N_TERM-1:0]  or_map;
    logic [N_OUT-1:0]              pol;
    out_mode_e                     mode;
    logic [N_TERM-1:0]             terms;
    logic [N_OUT-1:0]              func;

    sop_cfg_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
        .live_and(and_map), .live_or(or_map), .live_pol(pol), .live_mode(mode)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .din(din), .and_map(and_map), .terms(terms)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .terms(terms), .or_map(or_map), .pol(pol), .func(func)
    );

    sop_out_stage #(.N_OUT(N_OUT)) u_out (
        .func(func), .chip_en(chip_en), .mode(mode), .dout(dout), .doe(doe)
    );

    // R7: an inhibited array never drives a high level
    assert_inhibit_R7: assert property (@(posedge clk) disable iff (rst)
        !chip_en |-> (dout == '0));

    // R8: open-collector outputs only ever pull low
    assert_oc_low_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OC) |-> (dout == '0));

    // R8: an enabled open-collector output drives exactly when its function is 0
    assert_oc_drive_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OC && chip_en) |-> (doe == ~func));

    for (genvar t = 0; t < N_TERM; t++) begin : g_chk_term
        // R1: a term with no connections is always true
        assert_blank_term_R1: assert property (@(posedge clk) disable iff (rst)
            (and_map[t] == '0) |-> terms[t]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk_out
        // R4: with no connected term firing, the function equals the polarity bit
        assert_idle_pol_R4: assert property (@(posedge clk) disable iff (rst)
            ((or_map[o] & terms) == '0) |-> (func[o] == pol[o]));
    end

endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_commit = 1'b0;
    logic        chip_en = 1'b1;
    logic [15:0] din = '0;
    logic [7:0]  dout, doe;

    int errs = 0;
    int checks = 0;

    // bench model of the configuration
    logic [31:0] st_and [48];
    logic [31:0] lv_and [48];
    logic [47:0] st_or  [8];
    logic [47:0] lv_or  [8];
    logic [7:0]  st_pol, lv_pol;
    logic        st_mode, lv_mode;

    always #5 clk = ~clk;

    sop_array u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .chip_en(chip_en),
        .din(din), .dout(dout), .doe(doe)
    );

    initial begin
        #1000000;
        errs++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    function automatic void model_reset();
        for (int t = 0; t < 48; t++) begin st_and[t] = '1; lv_and[t] = '1; end
        for (int o = 0; o < 8; o++) begin st_or[o] = '1; lv_or[o] = '1; end
        st_pol = '0; lv_pol = '0; st_mode = 1'b0; lv_mode = 1'b0;
    endfunction

    function automatic void model_write(input logic [6:0] a, input logic [31:0] d);
        if (a < 48) st_and[a] = d;
        else if (a < 64) begin
            if (a[0] == 1'b0) st_or[(a-48)/2][31:0]  = d;
            else              st_or[(a-48)/2][47:32] = d[15:0];
        end else if (a == 64) begin
            st_pol = d[7:0]; st_mode = d[8];
        end
    endfunction

    function automatic void model_commit();
        for (int t = 0; t < 48; t++) lv_and[t] = st_and[t];
        for (int o = 0; o < 8; o++) lv_or[o] = st_or[o];
        lv_pol = st_pol; lv_mode = st_mode;
    endfunction

    function automatic logic [7:0] model_func(input logic [15:0] x);
        logic [47:0] tv;
        logic [7:0]  f;
        for (int t = 0; t < 48; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < 16; i++) begin
                if (lv_and[t][2*i] && !x[i]) tv[t] = 1'b0;
                if (lv_and[t][2*i+1] && x[i]) tv[t] = 1'b0;
            end
        end
        for (int o = 0; o < 8; o++) f[o] = lv_pol[o] ^ (|(lv_or[o] & tv));
        return f;
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(posedge clk); #1;
        cfg_commit = 1'b0;
        model_commit();
    endtask

    task automatic wr_with_commit(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_commit = 1'b1;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_commit = 1'b0;
        model_commit();
        model_write(a, d);
    endtask

    task automatic set_or(input int o, input logic [47:0] m);
        wr(7'(48 + 2*o), m[31:0]);
        wr(7'(49 + 2*o), {16'h0, m[47:32]});
    endtask

    task automatic check_out(input string req, input logic [15:0] x, input logic en);
        logic [7:0] f, e_dout, e_doe;
        din = x; chip_en = en;
        #1;
        f = model_func(x);
        if (lv_mode) begin
            e_dout = '0;
            e_doe  = en ? ~f : 8'h00;
        end else begin
            e_dout = en ? f : 8'h00;
            e_doe  = en ? 8'hFF : 8'h00;
        end
        checks++;
        if (dout !== e_dout || doe !== e_doe) begin
            errs++;
            $display("FAIL %s: din=%h en=%b actual dout=%h doe=%h expected dout=%h doe=%h",
                     req, x, en, dout, doe, e_dout, e_doe);
        end
    endtask

    task automatic t_reset();
        checks++;
        din = 16'h5A3C; chip_en = 1'b1; #1;
        if (dout !== 8'h00 || doe !== 8'hFF) begin
            errs++;
            $display("FAIL R6: actual dout=%h doe=%h expected dout=00 doe=ff", dout, doe);
        end
        check_out("R6", 16'hFFFF, 1'b1);
        check_out("R6", 16'h0000, 1'b1);
    endtask

    task automatic t_staging();
        wr(7'd0, 32'h0);
        set_or(0, 48'h1);
        check_out("R5 no commit", 16'h1234, 1'b1);
        commit();
        check_out("R5 after commit", 16'h1234, 1'b1);
        wr_with_commit(7'd64, 32'h0000_00FF);
        check_out("R5 write in commit cycle", 16'h1234, 1'b1);
        commit();
        check_out("R5 second commit", 16'h1234, 1'b1);
        wr(7'd64, 32'h0);
        commit();
    endtask

    task automatic t_and_terms();
        for (int o = 0; o < 8; o++) set_or(o, 48'h0);
        wr(7'd1, 32'h0000_0009);
        wr(7'd2, 32'h0000_0030);
        wr(7'd40, 32'h4000_0000);
        set_or(1, 48'h2);
        set_or(2, 48'h4);
        set_or(3, 48'h6);
        set_or(4, 48'h1 << 40);
        set_or(5, 48'h3);
        commit();
        for (int v = 0; v < 8; v++) begin
            check_out("R1", 16'(v), 1'b1);
            check_out("R2", 16'(v) | 16'h8000, 1'b1);
        end
        check_out("R3 upper word", 16'h8001, 1'b1);
        check_out("R3 upper word", 16'h7FFF, 1'b1);
    endtask

    task automatic t_polarity();
        wr(7'd64, 32'h0000_00A5);
        commit();
        for (int v = 0; v < 4; v++) check_out("R4", 16'(v * 16'h4001), 1'b1);
    endtask

    task automatic t_modes();
        check_out("R7 enabled", 16'h0001, 1'b1);
        check_out("R7 inhibited", 16'h0001, 1'b0);
        wr(7'd64, 32'h0000_01A5);
        commit();
        check_out("R8 enabled", 16'h0001, 1'b1);
        check_out("R8 enabled", 16'h8002, 1'b1);
        check_out("R8 inhibited", 16'h0001, 1'b0);
        checks++;
        if (doe !== 8'h00 || dout !== 8'h00) begin
            errs++;
            $display("FAIL R8: inhibited actual dout=%h doe=%h expected 00 00", dout, doe);
        end
    endtask

    task automatic t_comb();
        @(negedge clk);
        check_out("R9", 16'h0002, 1'b1);
        check_out("R9", 16'h0003, 1'b1);
        check_out("R9", 16'h0003, 1'b0);
    endtask

    task automatic t_random();
        for (int c = 0; c < 5; c++) begin
            for (int t = 0; t < 48; t++) begin
                logic [31:0] m = '0;
                for (int i = 0; i < 16; i++) begin
                    int r = $urandom % 16;
                    if (r < 3) m[2*i] = 1'b1;
                    else if (r < 6) m[2*i+1] = 1'b1;
                    else if (r == 6 && ($urandom % 8) == 0) begin
                        m[2*i] = 1'b1; m[2*i+1] = 1'b1;
                    end
                end
                wr(7'(t), m);
            end
            for (int o = 0; o < 8; o++) set_or(o, {16'($urandom), 32'($urandom)});
            wr(7'd64, {23'h0, 1'(c % 2), 8'($urandom)});
            commit();
            for (int v = 0; v < 30; v++)
                check_out("R3 random", 16'($urandom), 1'((v % 5) != 0));
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_staging();
        t_and_terms();
        t_polarity();
        t_modes();
        t_comb();
        t_random();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule